// File: doc/BRIEF.md
# Cascadable Add/Subtract Accumulator

This block is an accumulator built from a chain of identical one-bit slices. Each slice holds one register bit. On every rising clock edge the slice either clears that bit, loads it from a data input, adds the operand bit and incoming carry to it, or subtracts the operand bit and incoming borrow from it. The top level instantiates `N` slices, shares all control inputs across them, and ripples each slice's carry into the next. The result is an `N`-bit register that updates to `(acc ± operand)` modulo `2^N` in one clock.

The carry chain changes meaning with the mode. When adding, `cin` and `carry_out` are active-high carries. When subtracting, they are active-low borrows: a 0 means a borrow. For a stand-alone accumulator, drive `cin` to 0 for add and to 1 for subtract. To build a wider accumulator, feed `carry_out` of one instance into `cin` of the next. `carry_out` is combinational: it follows the current register value, `operand`, `cin` and `add_sel` without waiting for a clock edge.

Top module: `casc_accum`

## Requirements
- R1: When `rst` is 1 at a rising edge, `acc_q` becomes 0 after that edge, whatever `ld`, `ce`, `add_sel`, `operand`, `cin` or `ld_data` hold.
- R2: When `rst` is 0 and `ld` is 1 at a rising edge, `acc_q` becomes `ld_data` after that edge, even if `ce` is 0.
- R3: When `rst`, `ld` and `ce` are all 0 at a rising edge, `acc_q` keeps its value.
- R4: When `rst` and `ld` are 0, and `ce` and `add_sel` are 1, `acc_q` becomes `(acc_q + operand + cin) mod 2^N`.
- R5: When `rst` and `ld` are 0, `ce` is 1 and `add_sel` is 0, `acc_q` becomes `(acc_q - operand - (1 - cin)) mod 2^N`. Here `cin` = 0 means an incoming borrow.
- R6: With `add_sel` = 1, `carry_out` is 1 exactly when `acc_q + operand + cin >= 2^N`.
- R7: With `add_sel` = 0, `carry_out` is 0 (a borrow) exactly when `acc_q < operand + (1 - cin)`.
- R8: Before any reset or clock edge, the register starts at 0.
- R9: `carry_out` is combinational. A change on `operand`, `cin` or `add_sel` between edges changes `carry_out` without a clock edge, and `acc_q` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, highest priority |
| ce | input | 1 | Enables add/subtract updates |
| ld | input | 1 | Load request, overrides `ce` |
| ld_data | input | N | Value to load |
| add_sel | input | 1 | 1 = add, 0 = subtract |
| operand | input | N | Word added or subtracted |
| cin | input | 1 | Carry in (add) or active-low borrow in (subtract) |
| acc_q | output | N | Registered accumulator value |
| carry_out | output | 1 | Combinational carry out (add) or active-low borrow out (subtract) |

## Verification
A wrong slice bit shows up in `acc_q` on the first edge after it goes wrong. Because the next update adds to the stored value, the error then carries into every later result. A broken carry link, or a reversed borrow polarity, first appears on `carry_out`. That is visible in the same cycle the inputs are applied, before any edge. One edge later it appears as a wrong upper bit of `acc_q`. The bench therefore checks `carry_out` between edges and checks `acc_q` just after every edge, including edges where `rst` or `ld` should override the rest.

// File: rtl/casc_accum_pkg.sv
package casc_accum_pkg;

    typedef enum logic {
        MODE_SUB = 1'b0,
        MODE_ADD = 1'b1
    } acc_mode_e;

    typedef struct packed {
        logic bit_v;
    } slice_state_t;

endpackage

// File: rtl/acc_bit_alu.sv
module acc_bit_alu
    import casc_accum_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  logic      c_in,
    input  acc_mode_e mode,
    output logic      s_bit,
    output logic      c_out
);
    logic b_eff;

    // Subtract is a + ~b + c_in; the carry of that sum is the active-low borrow.
    always_comb begin
        b_eff = (mode == MODE_ADD) ? b_bit : ~b_bit;
        {c_out, s_bit} = {1'b0, a_bit} + {1'b0, b_eff} + {1'b0, c_in};
    end

endmodule

// File: rtl/acc_slice.sv
module acc_slice
    import casc_accum_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ce,
    input  logic      ld,
    input  logic      ld_bit,
    input  acc_mode_e mode,
    input  logic      op_bit,
    input  logic      c_in,
    output logic      q_bit,
    output logic      c_out
);
    slice_state_t st_q = '0;
    slice_state_t st_d;
    logic         sum_bit;

    acc_bit_alu u_alu (
        .a_bit (st_q.bit_v),
        .b_bit (op_bit),
        .c_in  (c_in),
        .mode  (mode),
        .s_bit (sum_bit),
        .c_out (c_out)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bit_v = 1'b0;
        end else if (ld) begin
            st_d.bit_v = ld_bit;
        end else if (ce) begin
            st_d.bit_v = sum_bit;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_bit = st_q.bit_v;

    AST_SLICE_HOLD: assert property (@(posedge clk) (!rst && !ld && !ce) |=> $stable(q_bit)); // R3

endmodule

// File: rtl/casc_accum.sv
module casc_accum
    import casc_accum_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ce,
    input  logic         ld,
    input  logic [N-1:0] ld_data,
    input  logic         add_sel,
    input  logic [N-1:0] operand,
    input  logic         cin,
    output logic [N-1:0] acc_q,
    output logic         carry_out
);
    localparam int CHAIN_W = N + 1;

    logic [CHAIN_W-1:0] chain;
    acc_mode_e          mode;

    assign mode     = add_sel ? MODE_ADD : MODE_SUB;
    assign chain[0] = cin;

    for (genvar i = 0; i < N; i++) begin : g_slice
        acc_slice u_slice (
            .clk    (clk),
            .rst    (rst),
            .ce     (ce),
            .ld     (ld),
            .ld_bit (ld_data[i]),
            .mode   (mode),
            .op_bit (operand[i]),
            .c_in   (chain[i]),
            .q_bit  (acc_q[i]),
            .c_out  (chain[i+1])
        );
    end

    assign carry_out = chain[N];

    // Word-level arithmetic references for the properties below.
    logic [N:0] chk_add;
    logic [N:0] chk_sub;
    assign chk_add = {1'b0, acc_q} + {1'b0, operand} + {{N{1'b0}}, cin};
    assign chk_sub = {1'b0, acc_q} - {1'b0, operand} - {{N{1'b0}}, ~cin};

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc_q == '0)); // R1
    AST_LOAD_WINS:    assert property (@(posedge clk) disable iff (rst) ld |=> (acc_q == $past(ld_data))); // R2
    AST_HOLD_WORD:    assert property (@(posedge clk) disable iff (rst) (!ld && !ce) |=> $stable(acc_q)); // R3
    AST_ADD_WORD:     assert property (@(posedge clk) disable iff (rst) (!ld && ce && add_sel) |=> (acc_q == $past(chk_add[N-1:0]))); // R4
    AST_SUB_WORD:     assert property (@(posedge clk) disable iff (rst) (!ld && ce && !add_sel) |=> (acc_q == $past(chk_sub[N-1:0]))); // R5
    AST_ADD_CARRY:    assert property (@(posedge clk) disable iff (rst) add_sel |-> (carry_out == chk_add[N])); // R6
    AST_SUB_BORROW:   assert property (@(posedge clk) disable iff (rst) !add_sel |-> (carry_out == !chk_sub[N])); // R7

endmodule

// File: tb/casc_accum_test.sv
`timescale 1ns/100ps
module casc_accum_test;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst, ce, ld, add_sel, cin;
    logic [N-1:0] ld_data, operand;
    logic [N-1:0] acc_q;
    logic         carry_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    casc_accum #(.N(N)) uut (
        .clk(clk), .rst(rst), .ce(ce), .ld(ld), .ld_data(ld_data),
        .add_sel(add_sel), .operand(operand), .cin(cin),
        .acc_q(acc_q), .carry_out(carry_out)
    );

    task automatic check(input string req, input logic [N:0] act, input logic [N:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // {rst, ld, ce, add_sel, operand[3:0], cin, ld_data[3:0], carry_out before edge, acc_q after edge}
    localparam logic [17:0] VEC [12] = '{
        18'b0_1_0_1_0000_0_0101_0_0101,  // R2 load 5 with ce low
        18'b0_0_1_1_0011_0_0000_0_1000,  // R4 5+3
        18'b0_0_1_1_1001_1_0000_1_0010,  // R4 R6 8+9+1 wraps
        18'b0_0_0_1_0111_1_0000_0_0010,  // R3 hold
        18'b0_0_1_0_0001_1_0000_1_0001,  // R5 R7 2-1
        18'b0_0_1_0_0001_1_0000_1_0000,  // R5 1-1
        18'b0_0_1_0_0001_1_0000_0_1111,  // R5 R7 0-1 borrows
        18'b0_0_1_0_0011_0_0000_1_1011,  // R5 15-3-borrow
        18'b0_1_0_0_0000_1_1001_1_1001,  // R2 load 9
        18'b1_1_1_1_0101_1_0111_0_0000,  // R1 reset beats all
        18'b0_0_1_1_1111_1_0000_1_0000,  // R4 R6 0+15+1
        18'b0_0_1_0_0000_0_0000_0_1111   // R5 R7 borrow-in only
    };

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [N-1:0] model;
        logic [N:0]   wide;
        rst = 1'b1; ce = 1'b0; ld = 1'b0; add_sel = 1'b1; cin = 1'b0;
        ld_data = '0; operand = '0;
        #0.5;
        check("R8", {1'b0, acc_q}, '0);
        @(posedge clk); #1;
        check("R1", {1'b0, acc_q}, '0);

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            {rst, ld, ce, add_sel, operand, cin, ld_data} = VEC[i][17:5];
            #1;
            check(add_sel ? "R6" : "R7", {{N{1'b0}}, carry_out}, {{N{1'b0}}, VEC[i][4]});
            @(posedge clk); #1;
            check("R1-R5 vec", {1'b0, acc_q}, {1'b0, VEC[i][3:0]});
        end

        // R9: accumulator at 15, no edge while operand and mode change
        @(negedge clk);
        rst = 0; ld = 0; ce = 0; add_sel = 1; cin = 0; operand = 4'd0;
        #0.5;
        check("R9", {{N{1'b0}}, carry_out}, '0);
        operand = 4'd1; #0.5;
        check("R9", {{N{1'b0}}, carry_out}, {{N{1'b0}}, 1'b1});
        add_sel = 0; cin = 1; operand = 4'd15; #0.5;
        check("R9", {{N{1'b0}}, carry_out}, {{N{1'b0}}, 1'b1});
        cin = 0; #0.5;
        check("R9", {{N{1'b0}}, carry_out}, '0);
        check("R9", {1'b0, acc_q}, {1'b0, 4'd15});

        // R3: ce low, no load, hold across several edges
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            check("R3", {1'b0, acc_q}, {1'b0, 4'd15});
        end

        // Random phase against an arithmetic model
        model = 4'd15;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            rst = ($urandom % 16) == 0;
            ld = ($urandom % 8) == 0;
            ce = $urandom % 2;
            add_sel = $urandom % 2;
            cin = $urandom % 2;
            operand = $urandom;
            ld_data = $urandom;
            #1;
            if (add_sel) begin
                wide = {1'b0, model} + {1'b0, operand} + {{N{1'b0}}, cin};
                check("R6", {{N{1'b0}}, carry_out}, {{N{1'b0}}, wide[N]});
            end else begin
                wide = {1'b0, model} - {1'b0, operand} - {{N{1'b0}}, ~cin};
                check("R7", {{N{1'b0}}, carry_out}, {{N{1'b0}}, ~wide[N]});
            end
            if (rst)      model = '0;
            else if (ld)  model = ld_data;
            else if (ce)  model = wide[N-1:0];
            @(posedge clk); #1;
            check(add_sel ? "R4 random" : "R5 random", {1'b0, acc_q}, {1'b0, model});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule